// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block serialises a stereo pair of PCM samples onto one audio data line, framed by a bit clock and a frame (left/right) clock. A 16-bit control word selects its behaviour. That word chooses one of four framing formats, a word width of 24, 20 or 16 bits, whether the block drives the two clocks itself or follows clocks supplied from outside, and a mute for each channel.

Every frame has 64 bit slots, numbered 0 to 63. In the I2S, left-justified and right-justified formats, the frame splits into two halves of 32 slots. In the DSP format, a one-slot sync pulse opens the frame and the two words follow back to back. Samples arrive MSB-aligned on 24-bit inputs. Samples and the control word are taken only at a frame boundary, so a frame in flight is never altered.

In master mode the block divides its system clock to make the bit clock. In slave mode it synchronises the external bit clock and frame clock into the system clock domain and locks its slot count to the frame-clock edges.

Top module: `audio_ser_tx`

## Requirements
- R1: After reset the block runs in master mode with the I2S format, 24-bit words and both channels unmuted. `bclk_o`, `lrclk_o` and `sdata_o` are low, and `clk_dir_o` is high.
- R2: A write on `cfg_we_i` takes effect only when `cfg_wdata_i[15:12]` is 4'b0001. The fields are: format in [6:5], width in [4:3], slave select in [2], right mute in [1] and left mute in [0]. Bits [11:7] are ignored.
- R3: Width code 00 gives 24 bits, 01 gives 20 bits, 10 gives 16 bits, and the reserved code 11 gives 24 bits. A word of width w sends input bits [23:24-w], MSB first.
- R4: Format 00 (I2S): the frame clock is low in slots 0 to 31, which carry the left word, and high in slots 32 to 63, which carry the right word. The MSB of each word sits in position 1 of its half.
- R5: Format 11 (left-justified) puts the MSB at position 0 of each half. Format 01 (right-justified) puts the LSB at position 31 of each half. The frame clock follows the same halves as in R4.
- R6: Format 10 (DSP): the frame clock is high in slot 0 only. The left MSB is in slot 1 and the right MSB is in slot 1+w, with no gap between the words.
- R7: Every slot that carries no word bit is driven to 0.
- R8: A channel whose mute bit is 1 sends all zeros, whatever its sample.
- R9: In master mode the bit-clock period is 2*HALF_DIV system clocks, a frame spans 64 bit clocks, and `clk_dir_o` is 1.
- R10: In slave mode `clk_dir_o` is 0 and `bclk_o` and `lrclk_o` are held low. A falling edge of `lrclk_i` starts slot 0 and a rising edge starts slot 32 in the non-DSP formats. In the DSP format a rising edge of `lrclk_i` starts slot 0.
- R11: `sdata_o` and `lrclk_o` change only at a falling edge of the active bit clock. They hold steady while the bit clock is high.
- R12: Samples and configuration are latched at the start of slot 0. A control write in the very clock cycle of that boundary applies to the frame that starts there; a write one cycle later waits for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 16 | Control word (address field in [15:12]) |
| smp_left_i | input | SMP_W | Left sample, MSB-aligned |
| smp_right_i | input | SMP_W | Right sample, MSB-aligned |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode, else low) |
| lrclk_o | output | 1 | Generated frame clock (master mode, else low) |
| clk_dir_o | output | 1 | 1 when the block drives the clocks |
| sdata_o | output | 1 | Serial audio data |

## Verification
The hard case is a control write that lands in the very system clock cycle where the frame boundary latches the configuration. Both paths then act on the same edge.

The bench measures the 256-cycle frame period from a falling edge of `lrclk_o`. It then places a write that switches I2S to left-justified exactly on the next boundary edge, and in a second run one cycle after that edge.

The frame captured right after the boundary must be left-justified in the first run and still I2S in the second. Mid-frame writes and sample changes are checked in the same way against an unaltered frame.

// File: rtl/audio_ser_pkg.sv
`timescale 1ns/1ps
package audio_ser_pkg;

  localparam int SLOT_W     = 6;
  localparam int HALF_SLOTS = 32;
  localparam logic [3:0] CFG_ADDR = 4'b0001;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_RJ  = 2'b01,
    FMT_DSP = 2'b10,
    FMT_LJ  = 2'b11
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] ww;
    logic       slave;
    logic       mute_r;
    logic       mute_l;
  } cfg_t;

  function automatic cfg_t cfg_decode(input logic [6:0] f);
    cfg_t c;
    c.fmt    = fmt_e'(f[6:5]);
    c.ww     = f[4:3];
    c.slave  = f[2];
    c.mute_r = f[1];
    c.mute_l = f[0];
    return c;
  endfunction

  // reserved code 11 falls back to 24
  function automatic logic [5:0] width_of(input logic [1:0] ww);
    case (ww)
      2'b01:   return 6'd20;
      2'b10:   return 6'd16;
      default: return 6'd24;
    endcase
  endfunction

endpackage

// File: rtl/audio_ser_cfg.sv
`timescale 1ns/1ps
module audio_ser_cfg
  import audio_ser_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  input  logic        bnd_i,
  output cfg_t        act_o,
  output cfg_t        nxt_o
);

  cfg_t pend_q, pend_d, act_q;
  logic hit;
  logic unused_rsvd;

  assign unused_rsvd = ^wdata_i[11:7];
  assign hit    = we_i && (wdata_i[15:12] == CFG_ADDR);
  // a write in the boundary cycle bypasses straight into the new frame
  assign pend_d = hit ? cfg_decode(wdata_i[6:0]) : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (bnd_i) act_q <= pend_d;
    end
  end

  assign act_o = act_q;
  assign nxt_o = pend_d;

  assert_act_only_at_bnd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> $stable(act_q));

endmodule

// File: rtl/audio_ser_clkgen.sv
`timescale 1ns/1ps
module audio_ser_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slave_i,
  input  logic bclk_i,
  input  logic lrclk_i,
  output logic fall_o,
  output logic lr_o,
  output logic bclk_o
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             bclk_q;
  logic             wrap;
  logic [2:0]       bs_q;
  logic [1:0]       ls_q;
  logic             m_fall, s_fall;

  assign wrap = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      div_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  // two-stage synchronisers, frame clock kept aligned with bit clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bs_q <= '0;
      ls_q <= '0;
    end else begin
      bs_q <= {bs_q[1:0], bclk_i};
      ls_q <= {ls_q[0], lrclk_i};
    end
  end

  assign m_fall = wrap && bclk_q;
  assign s_fall = bs_q[2] && !bs_q[1];
  assign fall_o = slave_i ? s_fall : m_fall;
  assign lr_o   = ls_q[1];
  assign bclk_o = bclk_q && !slave_i;

endmodule

// File: rtl/audio_ser_slot.sv
`timescale 1ns/1ps
module audio_ser_slot
  import audio_ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              slave_i,
  input  logic              dsp_i,
  input  logic              lr_i,
  output logic [SLOT_W-1:0] slot_nxt_o,
  output logic              bnd_o
);

  logic [SLOT_W-1:0] slot_q, slot_nxt;
  logic              lr_prev_q;

  always_comb begin
    slot_nxt = slot_q + 1'b1;
    if (slave_i) begin
      if (dsp_i) begin
        if (lr_i && !lr_prev_q) slot_nxt = '0;
      end else if (lr_i != lr_prev_q) begin
        slot_nxt = lr_i ? SLOT_W'(HALF_SLOTS) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q    <= '1;
      lr_prev_q <= 1'b0;
    end else if (fall_i) begin
      slot_q    <= slot_nxt;
      lr_prev_q <= lr_i;
    end
  end

  assign slot_nxt_o = slot_nxt;
  assign bnd_o      = fall_i && (slot_nxt == '0);

  assert_slot_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(slot_q));

  assert_master_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !slave_i) |=> (slot_q == $past(slot_q) + 1'b1));

endmodule

// File: rtl/audio_ser_bitsel.sv
`timescale 1ns/1ps
module audio_ser_bitsel
  import audio_ser_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  cfg_t              cfg_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SMP_W-1:0]  left_i,
  input  logic [SMP_W-1:0]  right_i,
  output logic              sd_o,
  output logic              lr_o,
  output logic              left_o
);

  localparam int IDX_W = $clog2(SMP_W);
  localparam logic [6:0] HALF7 = 7'(HALF_SLOTS);
  localparam logic [6:0] TOP7  = 7'(SMP_W - 1);

  logic [6:0]       w7, p7, s7, k7, b7;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             unused_b;

  always_comb begin
    w7     = {1'b0, width_of(cfg_i.ww)};
    p7     = {2'b0, slot_i[4:0]};
    s7     = {1'b0, slot_i};
    hit    = 1'b0;
    k7     = '0;
    left_o = ~slot_i[SLOT_W-1];
    case (cfg_i.fmt)
      FMT_I2S: begin
        hit = (p7 != 0) && (p7 <= w7);
        k7  = p7 - 7'd1;
      end
      FMT_LJ: begin
        hit = p7 < w7;
        k7  = p7;
      end
      FMT_RJ: begin
        hit = p7 >= (HALF7 - w7);
        k7  = p7 - (HALF7 - w7);
      end
      FMT_DSP: begin
        if ((s7 != 0) && (s7 <= w7)) begin
          left_o = 1'b1;
          hit    = 1'b1;
          k7     = s7 - 7'd1;
        end else if ((s7 > w7) && (s7 <= {w7[5:0], 1'b0})) begin
          left_o = 1'b0;
          hit    = 1'b1;
          k7     = s7 - 7'd1 - w7;
        end
      end
      default: ;
    endcase
  end

  assign b7       = TOP7 - k7;
  assign idx      = b7[IDX_W-1:0];
  assign unused_b = ^b7[6:IDX_W];

  assign sd_o = hit && (left_o ? (!cfg_i.mute_l && left_i[idx])
                               : (!cfg_i.mute_r && right_i[idx]));
  assign lr_o = (cfg_i.fmt == FMT_DSP) ? (slot_i == '0) : slot_i[SLOT_W-1];

endmodule

// File: rtl/audio_ser_tx.sv
`timescale 1ns/1ps
module audio_ser_tx
  import audio_ser_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int SMP_W    = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [15:0]      cfg_wdata_i,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             clk_dir_o,
  output logic             sdata_o
);

  cfg_t              act, nxt, use_c;
  logic              fall, bnd, lr_s, bclk_int;
  logic [SLOT_W-1:0] slot_nxt;
  logic [SMP_W-1:0]  l_q, r_q, l_use, r_use;
  logic              sd_bit, lr_bit, chan_left;
  logic              sdata_q, lrclk_q;

  audio_ser_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .bnd_i   (bnd),
    .act_o   (act),
    .nxt_o   (nxt)
  );

  audio_ser_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slave_i (act.slave),
    .bclk_i  (bclk_i),
    .lrclk_i (lrclk_i),
    .fall_o  (fall),
    .lr_o    (lr_s),
    .bclk_o  (bclk_int)
  );

  audio_ser_slot u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall),
    .slave_i    (act.slave),
    .dsp_i      (act.fmt == FMT_DSP),
    .lr_i       (lr_s),
    .slot_nxt_o (slot_nxt),
    .bnd_o      (bnd)
  );

  // boundary slot uses the values being latched on this edge
  assign use_c = bnd ? nxt : act;
  assign l_use = bnd ? smp_left_i  : l_q;
  assign r_use = bnd ? smp_right_i : r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q <= '0;
      r_q <= '0;
    end else if (bnd) begin
      l_q <= smp_left_i;
      r_q <= smp_right_i;
    end
  end

  audio_ser_bitsel #(.SMP_W(SMP_W)) u_bitsel (
    .cfg_i   (use_c),
    .slot_i  (slot_nxt),
    .left_i  (l_use),
    .right_i (r_use),
    .sd_o    (sd_bit),
    .lr_o    (lr_bit),
    .left_o  (chan_left)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdata_q <= 1'b0;
      lrclk_q <= 1'b0;
    end else if (fall) begin
      sdata_q <= sd_bit;
      lrclk_q <= lr_bit;
    end
  end

  assign bclk_o    = bclk_int;
  assign lrclk_o   = lrclk_q && !act.slave;
  assign clk_dir_o = !act.slave;
  assign sdata_o   = sdata_q;

  assert_sdata_on_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(sdata_o));

  assert_slave_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act.slave |-> (!bclk_o && !lrclk_o));

  assert_mute_left_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && use_c.mute_l && chan_left) |=> !sdata_o);

  assert_dsp_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && (use_c.fmt == FMT_DSP) && (slot_nxt != '0)) |=> !lrclk_q);

endmodule

// File: tb/audio_ser_tx_bench.sv
`timescale 1ns/1ps
module audio_ser_tx_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [23:0] smp_left_i = '0;
  logic [23:0] smp_right_i = '0;
  logic        bclk_i = 1'b1;
  logic        lrclk_i = 1'b0;
  logic        bclk_o, lrclk_o, clk_dir_o, sdata_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;
  bit  slave_sel = 1'b0;

  audio_ser_tx u_audio_ser_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .smp_left_i  (smp_left_i),
    .smp_right_i (smp_right_i),
    .bclk_i      (bclk_i),
    .lrclk_i     (lrclk_i),
    .bclk_o      (bclk_o),
    .lrclk_o     (lrclk_o),
    .clk_dir_o   (clk_dir_o),
    .sdata_o     (sdata_o)
  );

  always #5 clk_i = ~clk_i;

  // external clock source for slave runs: 16 system clocks per bit
  int gs = 0;
  initial begin
    forever begin
      repeat (8) @(negedge clk_i);
      bclk_i  = 1'b0;
      gs      = (gs + 1) % 64;
      lrclk_i = (gs >= 32);
      repeat (8) @(negedge clk_i);
      bclk_i  = 1'b1;
    end
  end

  logic rx_bclk, rx_lrclk;
  assign rx_bclk  = slave_sel ? bclk_i  : bclk_o;
  assign rx_lrclk = slave_sel ? lrclk_i : lrclk_o;

  logic h1 = 1'b0, h2 = 1'b0, sd_h1 = 1'b0;
  always @(posedge rx_bclk) begin
    h1    <= rx_lrclk;
    h2    <= h1;
    sd_h1 <= sdata_o;
  end

  // {control word, left, right}
  localparam int NV = 13;
  localparam logic [63:0] VECS [NV] = '{
    {16'h1000, 24'hA5C3F1, 24'h3C96E7},
    {16'h1008, 24'hA5C3F1, 24'h3C96E7},
    {16'h1010, 24'hA5C3F1, 24'h3C96E7},
    {16'h1060, 24'h81F00F, 24'h7E0FF1},
    {16'h1078, 24'h81F00F, 24'h7E0FF1},
    {16'h1020, 24'hC0FFEE, 24'h123457},
    {16'h1030, 24'hC0FFEE, 24'h123457},
    {16'h1040, 24'hF0E1D3, 24'h0F1E2D},
    {16'h1048, 24'hF0E1D3, 24'h0F1E2D},
    {16'h1001, 24'hFFFFFF, 24'hB6DB6D},
    {16'h1062, 24'h9ABCDE, 24'hFFFFFF},
    {16'h1043, 24'hFFFFFF, 24'hFFFFFF},
    {16'h1F80, 24'h5A5A5B, 24'hDEADBF}
  };

  function automatic logic [63:0] exp_sd(logic [15:0] w, logic [23:0] l, logic [23:0] r);
    logic [63:0] f = '0;
    int n = (w[4:3] == 2'b01) ? 20 : (w[4:3] == 2'b10) ? 16 : 24;
    for (int s = 0; s < 64; s++) begin
      int  p = s % 32;
      bit  lf = (s < 32);
      int  k = -1;
      case (w[6:5])
        2'b00: if (p >= 1 && p <= n) k = p - 1;
        2'b11: if (p < n) k = p;
        2'b01: if (p >= 32 - n) k = p - (32 - n);
        default: begin
          if (s >= 1 && s <= n) begin lf = 1'b1; k = s - 1; end
          else if (s > n && s <= 2 * n) begin lf = 1'b0; k = s - 1 - n; end
        end
      endcase
      if (k >= 0)
        f[s] = lf ? (!w[0] && l[23-k]) : (!w[1] && r[23-k]);
    end
    return f;
  endfunction

  function automatic logic [63:0] exp_lr(logic [15:0] w);
    return (w[6:5] == 2'b10) ? 64'h1 : 64'hFFFFFFFF_00000000;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [15:0] w);
    @(negedge clk_i);
    cfg_we_i    = 1'b1;
    cfg_wdata_i = w;
    @(negedge clk_i);
    cfg_we_i    = 1'b0;
  endtask

  task automatic settle();
    repeat (130) @(posedge rx_bclk);
  endtask

  task automatic grab(input bit dsp, input int poke_at, input logic [23:0] pl,
                      input logic [23:0] pr, input bit pcfg_en, input logic [15:0] pcfg,
                      output logic [63:0] sd, output logic [63:0] lr);
    int  guard = 0;
    bit  found = 1'b0;
    sd = '0;
    lr = '0;
    while (!found && guard < 300) begin
      @(posedge rx_bclk);
      #1;
      guard++;
      found = dsp ? (h1 && !h2) : (!h1 && h2);
    end
    if (!found) begin
      n_chk++;
      n_err++;
      $display("FAIL frame marker R4/R6 act=absent exp=present");
    end
    sd[0] = sd_h1;
    lr[0] = h1;
    for (int i = 1; i < 64; i++) begin
      @(posedge rx_bclk);
      #1;
      sd[i] = sd_h1;
      lr[i] = h1;
      if (i == poke_at) begin
        smp_left_i  = pl;
        smp_right_i = pr;
        if (pcfg_en) wr_cfg(pcfg);
      end
    end
  endtask

  task automatic run_vec(string tag, logic [15:0] w, logic [23:0] l, logic [23:0] r);
    logic [63:0] sd, lr;
    wr_cfg(w);
    smp_left_i  = l;
    smp_right_i = r;
    settle();
    grab(w[6:5] == 2'b10, -1, '0, '0, 1'b0, '0, sd, lr);
    chk({tag, " data"}, sd, exp_sd(w, l, r));
    chk({tag, " frame clock"}, lr, exp_lr(w));
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1 bclk_o in reset", {63'b0, bclk_o}, 64'h0);
    chk("R1 lrclk/sdata in reset", {62'b0, lrclk_o, sdata_o}, 64'h0);
    chk("R1 clk_dir_o in reset", {63'b0, clk_dir_o}, 64'h1);
    @(negedge clk_i);
    rst_ni      = 1'b1;
    smp_left_i  = 24'hD2B4C3;
    smp_right_i = 24'h2B4C3D;
    begin
      logic [63:0] sd, lr;
      settle();
      grab(1'b0, -1, '0, '0, 1'b0, '0, sd, lr);
      chk("R1 default I2S 24-bit frame", sd, exp_sd(16'h1000, 24'hD2B4C3, 24'h2B4C3D));
    end

    // R9 bit clock period
    begin
      realtime t0, t1;
      @(posedge bclk_o) t0 = $realtime;
      @(posedge bclk_o) t1 = $realtime;
      chk("R9 bclk period ns", 64'(int'(t1 - t0)), 64'd40);
    end

    // table: formats R4 R5 R6, widths R3, idle slots R7, mute R8, ignored bits R2
    for (int v = 0; v < NV; v++) begin
      string t;
      t = $sformatf("vec%0d R2/R3/R4/R5/R6/R7/R8", v);
      run_vec(t, VECS[v][63:48], VECS[v][47:24], VECS[v][23:0]);
    end

    // R11: data holds while bclk high
    begin
      int bad = 0;
      logic a, b;
      wr_cfg(16'h1000);
      smp_left_i  = 24'hAAAAAA;
      smp_right_i = 24'h555555;
      settle();
      for (int i = 0; i < 64; i++) begin
        @(posedge bclk_o);
        #1 a = sdata_o;
        #10 b = sdata_o;
        if (a !== b) bad++;
      end
      chk("R11 sdata change while bclk high", 64'(bad), 64'd0);
    end

    // R12 write on the boundary cycle applies to that frame
    begin
      logic [63:0] sd, lr;
      wr_cfg(16'h1000);
      smp_left_i  = 24'hE38E39;
      smp_right_i = 24'h1C71C7;
      settle();
      @(negedge lrclk_o);
      repeat (255) @(posedge clk_i);
      @(negedge clk_i);
      cfg_we_i    = 1'b1;
      cfg_wdata_i = 16'h1060;
      @(negedge clk_i);
      cfg_we_i    = 1'b0;
      grab(1'b0, -1, '0, '0, 1'b0, '0, sd, lr);
      chk("R12 write on boundary cycle", sd, exp_sd(16'h1060, 24'hE38E39, 24'h1C71C7));
    end

    // R12 write one cycle late waits a frame
    begin
      logic [63:0] sd, lr;
      wr_cfg(16'h1000);
      settle();
      @(negedge lrclk_o);
      repeat (256) @(posedge clk_i);
      @(negedge clk_i);
      cfg_we_i    = 1'b1;
      cfg_wdata_i = 16'h1060;
      @(negedge clk_i);
      cfg_we_i    = 1'b0;
      grab(1'b0, -1, '0, '0, 1'b0, '0, sd, lr);
      chk("R12 write after boundary cycle", sd, exp_sd(16'h1000, 24'hE38E39, 24'h1C71C7));
    end

    // R12 mid-frame sample and config change, R8 applies at the next frame
    begin
      logic [63:0] sd, lr;
      wr_cfg(16'h1000);
      smp_left_i  = 24'h13579B;
      smp_right_i = 24'hECA864;
      settle();
      grab(1'b0, 8, 24'hFFFFFF, 24'hFFFFFF, 1'b1, 16'h1003, sd, lr);
      chk("R12 frame unaltered by mid-frame change", sd, exp_sd(16'h1000, 24'h13579B, 24'hECA864));
      grab(1'b0, -1, '0, '0, 1'b0, '0, sd, lr);
      chk("R8 both muted next frame", sd, 64'h0);
    end

    // R2 wrong address ignored: would unmute if taken
    begin
      logic [63:0] sd, lr;
      wr_cfg(16'h2000);
      settle();
      grab(1'b0, -1, '0, '0, 1'b0, '0, sd, lr);
      chk("R2 write to other address ignored", sd, 64'h0);
    end

    // R10 slave mode
    begin
      logic [63:0] sd, lr;
      wr_cfg(16'h1004);
      smp_left_i  = 24'h6B5A49;
      smp_right_i = 24'h94A5B6;
      repeat (600) @(posedge clk_i);
      slave_sel = 1'b1;
      settle();
      grab(1'b0, -1, '0, '0, 1'b0, '0, sd, lr);
      chk("R10 slave I2S 24-bit", sd, exp_sd(16'h1004, 24'h6B5A49, 24'h94A5B6));
      #1;
      chk("R10 slave outputs quiet", {61'b0, bclk_o, lrclk_o, clk_dir_o}, 64'h0);
      wr_cfg(16'h1034);
      settle();
      grab(1'b0, -1, '0, '0, 1'b0, '0, sd, lr);
      chk("R10 slave right-justified 16-bit", sd, exp_sd(16'h1034, 24'h6B5A49, 24'h94A5B6));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule